// File: doc/BRIEF.md
# Shared-Bus Four-Register Datapath

This block is the data half of a tiny accumulator-style processor. Four general registers, a hidden operand latch and a hidden result latch share one W-bit bus. Every cycle, at most one source drives the bus. The source is one of the four general registers, the result latch, or an external data word. Any set of registers may capture the bus value on the next rising edge.

A separate control block decodes and sequences instructions and drives this datapath. It uses one-hot drive enables, per-register load enables and an add/subtract select. Arithmetic takes three steps:
1. Latch the first operand into the hidden operand latch A.
2. Drive the second operand onto the bus while the result latch G loads A plus or minus the bus.
3. Drive G onto the bus to write the result back.

All register contents are brought out for observation. Reset is synchronous and active high.

Top module: `bus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, R0..R3, A and G all become zero on that edge.
- R2: `bus_out` is combinational. It equals R0..R3 when `drv_en` bit 0..3 is set, G when bit 4 is set, and `ext_data` when bit 5 is set.
- R3: With `drv_en` all zero, `bus_out` is zero.
- R4: A register captures `bus_out` at the rising edge when its `load_en` bit is high, and otherwise holds its value. `load_en` bits 0..3 select R0..R3 and bit 4 selects A.
- R5: Several load enables raised in the same cycle all capture the same bus value.
- R6: With `load_en` bit 5 high and `sub_mode` low, G captures (A + bus) mod 2^W. The carry-out is discarded.
- R7: With `load_en` bit 5 high and `sub_mode` high, G captures (A - bus) mod 2^W, formed as A + ~bus + 1.
- R8: At most one `drv_en` bit is high in any cycle. The controller must guarantee this, and the bench never drives anything else.
- R9: A register may drive the bus and load in the same cycle. In particular, with G driving and G loading, G becomes A ± old G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| drv_en | input | 6 | One-hot bus source select: R0..R3, G, external |
| load_en | input | 6 | Load enables: R0..R3, A, G |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| ext_data | input | W | External data word |
| bus_out | output | W | Current bus value |
| gp_q | output | 4*W | R0..R3 contents, R0 in the low W bits |
| a_q | output | W | Operand latch A |
| g_q | output | W | Result latch G |

## Verification
The hardest states to reach from the ports are those where a register feeds itself. One is G driving the bus while G loads. Another is a subtraction that wraps below zero with the carry thrown away. Both need A and G preloaded through earlier bus transfers. Directed sequences set up A and G first and then trigger these cases. Seeded random cycles, each with one-hot or idle drive enables and arbitrary load masks, then mix transfers among all six storage elements.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int NUM_GP  = 4;
  localparam int NUM_SRC = NUM_GP + 2;
  localparam int NUM_LD  = NUM_GP + 2;
  // drive-enable bit positions
  localparam int SRC_G   = NUM_GP;
  localparam int SRC_EXT = NUM_GP + 1;
  // load-enable bit positions
  localparam int LD_A    = NUM_GP;
  localparam int LD_G    = NUM_GP + 1;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/dp_bus_mux.sv
module dp_bus_mux #(
  parameter int W = 8,
  parameter int N = 6
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        y
);
  // AND-OR selector: all zero when nothing is selected
  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++)
      y = y | (src[i] & {W{sel[i]}});
  end
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] res
);
  logic [W-1:0] opb_x;
  always_comb begin
    opb_x = opb ^ {W{sub}};
    res   = opa + opb_x + {{(W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  drv_en,
  input  logic [NUM_LD-1:0]   load_en,
  input  logic                sub_mode,
  input  logic [W-1:0]        ext_data,
  output logic [W-1:0]        bus_out,
  output logic [NUM_GP*W-1:0] gp_q,
  output logic [W-1:0]        a_q,
  output logic [W-1:0]        g_q
);
  localparam int NUM_STORE = NUM_LD;

  logic [NUM_STORE-1:0][W-1:0] store_q;
  logic [NUM_STORE-1:0][W-1:0] store_d;
  logic [NUM_SRC-1:0][W-1:0]   bus_src;
  logic [W-1:0]                alu_res;

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    if (i == LD_G) begin : g_res
      assign store_d[i] = alu_res;
    end else begin : g_bus
      assign store_d[i] = bus_out;
    end
    dp_reg #(.W(W)) u_reg (
      .clk(clk), .rst(rst), .ld(load_en[i]), .d(store_d[i]), .q(store_q[i])
    );
  end

  for (genvar i = 0; i < NUM_GP; i++) begin : g_src
    assign bus_src[i]        = store_q[i];
    assign gp_q[i*W +: W]    = store_q[i];
  end
  assign bus_src[SRC_G]   = store_q[LD_G];
  assign bus_src[SRC_EXT] = ext_data;

  dp_bus_mux #(.W(W), .N(NUM_SRC)) u_bus (
    .sel(drv_en), .src(bus_src), .y(bus_out)
  );

  dp_addsub #(.W(W)) u_alu (
    .opa(store_q[LD_A]), .opb(bus_out), .sub(sub_mode), .res(alu_res)
  );

  assign a_q = store_q[LD_A];
  assign g_q = store_q[LD_G];
endmodule

// File: rtl/dp_checker.sv
module dp_checker
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_SRC-1:0]  drv_en,
  input logic [NUM_LD-1:0]   load_en,
  input logic                sub_mode,
  input logic [W-1:0]        ext_data,
  input logic [W-1:0]        bus_out,
  input logic [NUM_GP*W-1:0] gp_q,
  input logic [W-1:0]        a_q,
  input logic [W-1:0]        g_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (gp_q == '0 && a_q == '0 && g_q == '0));
  // R8
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_en));
  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_en == '0) |-> (bus_out == '0));
  // R2
  ext_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_en == (NUM_SRC'(1) << SRC_EXT)) |-> (bus_out == ext_data));
  // R4
  a_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en[LD_A] |=> (a_q == $past(bus_out)));
  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en[LD_A] |=> $stable(a_q));
  // R6
  g_add_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en[LD_G] && !sub_mode) |=> (g_q == W'($past(a_q) + $past(bus_out))));
  // R7
  g_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en[LD_G] && sub_mode) |=> (g_q == W'($past(a_q) - $past(bus_out))));
endmodule

bind bus_datapath dp_checker #(.W(W)) u_dp_checker (
  .clk(clk), .rst(rst), .drv_en(drv_en), .load_en(load_en),
  .sub_mode(sub_mode), .ext_data(ext_data), .bus_out(bus_out),
  .gp_q(gp_q), .a_q(a_q), .g_q(g_q)
);

// File: tb/bus_datapath_test.sv
module bus_datapath_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   drv_en = '0;
  logic [5:0]   load_en = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] ext_data = '0;
  logic [W-1:0] bus_out;
  logic [4*W-1:0] gp_q;
  logic [W-1:0] a_q, g_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_r [4];
  logic [W-1:0] m_a, m_g;

  bus_datapath #(.W(W)) uut (
    .clk(clk), .rst(rst), .drv_en(drv_en), .load_en(load_en),
    .sub_mode(sub_mode), .ext_data(ext_data), .bus_out(bus_out),
    .gp_q(gp_q), .a_q(a_q), .g_q(g_q)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_bus(input logic [5:0] d, input logic [W-1:0] x);
    case (d)
      6'b000001: return m_r[0];
      6'b000010: return m_r[1];
      6'b000100: return m_r[2];
      6'b001000: return m_r[3];
      6'b010000: return m_g;
      6'b100000: return x;
      default:   return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_alu(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic s);
    return s ? W'(a - b) : W'(a + b);
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < 4; i++) chk(tag, $sformatf("R%0d", i), gp_q[i*W +: W], m_r[i]);
    chk(tag, "A", a_q, m_a);
    chk(tag, "G", g_q, m_g);
  endtask

  // one bus cycle: drive, check bus before edge, update model, check after edge
  task automatic step(input logic [5:0] d, input logic [5:0] l, input logic s,
                      input logic [W-1:0] x, input string tag);
    logic [W-1:0] b;
    @(negedge clk);
    drv_en = d; load_en = l; sub_mode = s; ext_data = x;
    #2;
    b = exp_bus(d, x);
    chk((d == 0) ? "R3" : "R2", "bus", bus_out, b);
    @(posedge clk);
    for (int i = 0; i < 4; i++) if (l[i]) m_r[i] = b;
    if (l[4]) m_a = b;
    if (l[5]) m_g = exp_alu(m_a_prev(l, b), b, s);
    #2;
    check_regs(tag);
  endtask

  // A value seen by the adder is the one before this edge
  logic [W-1:0] a_before;
  function automatic logic [W-1:0] m_a_prev(input logic [5:0] l, input logic [W-1:0] b);
    return a_before;
  endfunction

  task automatic op(input logic [5:0] d, input logic [5:0] l, input logic s,
                    input logic [W-1:0] x, input string tag);
    a_before = m_a;
    step(d, l, s, x, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; drv_en = '0; load_en = '0;
    repeat (2) @(posedge clk);
    #2;
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    m_a = '0; m_g = '0;
    check_regs("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_r[i] = 'x;
    do_reset();

    // R4 load each general register from external data
    op(6'b100000, 6'b000001, 1'b0, 8'h11, "R4");
    op(6'b100000, 6'b000010, 1'b0, 8'h22, "R4");
    op(6'b100000, 6'b000100, 1'b0, 8'h03, "R4");
    op(6'b100000, 6'b001000, 1'b0, 8'h05, "R4");
    // R3 idle bus, nothing loads
    op(6'b000000, 6'b000000, 1'b0, 8'hFF, "R3");
    // R2 move R0 -> R3
    op(6'b000001, 6'b001000, 1'b0, 8'h00, "R2");
    // R7 underflow: A = 3, G = 3 - 5
    op(6'b000100, 6'b010000, 1'b0, 8'h00, "R7");
    op(6'b100000, 6'b100000, 1'b1, 8'h05, "R7");
    chk("R7", "wrap", g_q, 8'hFE);
    // R6 overflow: A = 200, G = 200 + 100
    op(6'b100000, 6'b010000, 1'b0, 8'd200, "R6");
    op(6'b100000, 6'b100000, 1'b0, 8'd100, "R6");
    chk("R6", "carry dropped", g_q, 8'd44);
    // R5 G onto bus into all four registers and A
    op(6'b010000, 6'b011111, 1'b0, 8'h00, "R5");
    // R9 G drives and loads: G <= A + G, then A - G
    op(6'b010000, 6'b100000, 1'b0, 8'h00, "R9");
    op(6'b010000, 6'b100000, 1'b1, 8'h00, "R9");
    // R9 register drives and loads itself
    op(6'b000010, 6'b000010, 1'b0, 8'h00, "R9");

    // seeded random mix, R8: drive enables kept one-hot or idle
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [5:0] d;
      k = $urandom_range(0, 6);
      d = (k == 6) ? 6'b0 : 6'(1 << k);
      op(d, 6'($urandom), 1'($urandom), W'($urandom),
         "R4");
    end

    do_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule